// File: doc/BRIEF.md
# Grouped Multi-Unit Event Counter Monitor

This block is a hardware performance monitor shared by four functional units. Each unit owns a bank of five 32-bit counters. A unit presents eighty event lines, organised as sixteen groups of five, and one mode control word picks which group each unit counts. Within a group, event position c always feeds counter c of that unit. Counting is gated by two live machine-state bits: a process-mark bit, which lets software measure only the processes it has tagged, and a problem-state bit, which is high while a user-level program runs. A qualifier field in the mode control word states which combinations of those two bits are counted.

Software reaches the mode control word, a per-unit overflow status word and all twenty counters through a simple programmed I/O port. Reads return data one cycle after the request. A counter that passes 2^32 - 1 wraps to zero without any other effect, and it sets the sticky overflow bit of its unit. That bit stays set until software clears it by writing a one to it.

The programmed I/O port is driven by a two-state machine. `PIO_IDLE` is entered at reset and on any cycle with no read request. `PIO_RESP` is entered on the edge that accepts a read request and drives the read-valid strobe. Under back-to-back reads the machine stays in `PIO_RESP`. With no read request it returns to `PIO_IDLE`.

Top module: `hm_grouped_monitor`

## Requirements
- R1: After reset all twenty counters, the mode control word and the overflow status word read zero, and `pio_rvalid` is low.
- R2: Counter c of unit u increments by one on a clock edge where event line u*80 + g*5 + c is high and counting is allowed. Here g is the unit's 4-bit group select, held in mode control bits [4u+3:4u]. Every other event line has no effect on that counter.
- R3: A counter at 0xFFFFFFFF that increments wraps to 0 and sets bit u of the overflow status word (address 1). Writing the status word clears each bit written as one. A wrap on the same edge as a clear leaves the bit set.
- R4: Mode control bits [17:16] qualify on the process-mark input: 00 counts regardless, 01 counts only with `proc_mark` high, 10 counts only with `proc_mark` low, 11 never counts.
- R5: Mode control bits [19:18] qualify on the problem-state input (`user_mode` high means user level): 00 both, 01 user only, 10 supervisor only, 11 never. A counter increments only when both R4 and R5 allow it.
- R6: A new group select takes effect for events on the edge after the write that sets it. Changing the select leaves all counter values unchanged.
- R7: A write to address 2 + 5u + c loads counter c of unit u. A write on the same edge as a qualifying event wins over the event. A loaded value never sets an overflow bit.
- R8: A read request (`pio_en` high, `pio_we` low) is answered on the next cycle with `pio_rvalid` high and `pio_rdata` holding the addressed value as it stood before that edge. `pio_rvalid` is low in every other cycle. Addresses 22 to 31 read zero.
- R9: The mode control word is at address 0. It keeps bits [19:0] of the written data and reads zero in bits [31:20].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unit_evt | input | 320 | Event lines, 80 per unit, unit u at [80u+79:80u] |
| proc_mark | input | 1 | Live process-mark bit of the running process |
| user_mode | input | 1 | Live problem-state bit, high at user level |
| pio_en | input | 1 | Programmed I/O access request |
| pio_we | input | 1 | High for write, low for read |
| pio_addr | input | 5 | Register address |
| pio_wdata | input | 32 | Write data |
| pio_rdata | output | 32 | Read data, valid with pio_rvalid |
| pio_rvalid | output | 1 | Read response strobe, one cycle after a read request |

## Verification
The bench steps through all sixteen group selects, with every unit on a different group, and compares all twenty counters after each step. A design that routes the wrong group, the wrong position within a group, or another unit's lines shows a count in the wrong counter. It tries every combination of the two qualifier fields and the two machine-state bits. A swapped polarity or a missed "never" code makes a counter move, or stay still, in the wrong case. It also loads a counter with all ones so that it wraps, which shows whether the overflow bit is set and cleared correctly. It writes a counter on the same edge as one of its events, which catches a design that lets the event win over the load. Finally it reads back unmapped addresses and the unused upper control bits, which must return zero.

// File: rtl/hm_pkg.sv
package hm_pkg;

    typedef enum logic [1:0] {
        QM_ANY   = 2'b00,
        QM_SET   = 2'b01,
        QM_CLEAR = 2'b10,
        QM_NEVER = 2'b11
    } qual_mode_e;

    typedef enum logic {
        PIO_IDLE = 1'b0,
        PIO_RESP = 1'b1
    } pio_state_e;

    localparam int ADDR_CTRL     = 0;
    localparam int ADDR_STAT     = 1;
    localparam int ADDR_CNT_BASE = 2;

endpackage

// File: rtl/hm_qualify.sv
module hm_qualify
    import hm_pkg::*;
(
    input  logic [1:0] mark_mode,
    input  logic [1:0] priv_mode,
    input  logic       proc_mark,
    input  logic       user_mode,
    output logic       count_ok
);
    logic mark_ok;
    logic priv_ok;

    always_comb begin
        unique case (qual_mode_e'(mark_mode))
            QM_ANY:   mark_ok = 1'b1;
            QM_SET:   mark_ok = proc_mark;
            QM_CLEAR: mark_ok = ~proc_mark;
            QM_NEVER: mark_ok = 1'b0;
        endcase
    end

    always_comb begin
        unique case (qual_mode_e'(priv_mode))
            QM_ANY:   priv_ok = 1'b1;
            QM_SET:   priv_ok = user_mode;
            QM_CLEAR: priv_ok = ~user_mode;
            QM_NEVER: priv_ok = 1'b0;
        endcase
    end

    assign count_ok = mark_ok & priv_ok;
endmodule

// File: rtl/hm_unit_bank.sv
module hm_unit_bank #(
    parameter int N_CTRS   = 5,
    parameter int N_GROUPS = 16,
    parameter int CNT_W    = 32,
    localparam int SEL_W   = $clog2(N_GROUPS),
    localparam int EV_W    = N_GROUPS * N_CTRS
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [EV_W-1:0]           evt,
    input  logic [SEL_W-1:0]          sel,
    input  logic                      count_ok,
    input  logic [N_CTRS-1:0]         wr,
    input  logic [CNT_W-1:0]          wdata,
    input  logic                      ovf_clr,
    output logic [N_CTRS*CNT_W-1:0]   cnt,
    output logic                      ovf
);
    logic [N_CTRS-1:0] wrap;

    for (genvar c = 0; c < N_CTRS; c++) begin : g_ctr
        logic [N_GROUPS-1:0] col;
        logic                hit;
        logic [CNT_W-1:0]    val_q;

        for (genvar g = 0; g < N_GROUPS; g++) begin : g_col
            assign col[g] = evt[g*N_CTRS + c];
        end

        assign hit     = col[sel] & count_ok;
        assign wrap[c] = ~wr[c] & hit & (&val_q);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                val_q <= '0;
            end else if (wr[c]) begin
                val_q <= wdata;
            end else if (hit) begin
                val_q <= val_q + CNT_W'(1);
            end
        end

        assign cnt[c*CNT_W +: CNT_W] = val_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ovf <= 1'b0;
        end else if (|wrap) begin
            ovf <= 1'b1;
        end else if (ovf_clr) begin
            ovf <= 1'b0;
        end
    end
endmodule

// File: rtl/hm_pio.sv
module hm_pio
    import hm_pkg::*;
#(
    parameter int N_UNITS = 4,
    parameter int N_CTRS  = 5,
    parameter int CNT_W   = 32,
    parameter int CTRL_W  = 20,
    parameter int ADDR_W  = 5,
    localparam int N_CNT  = N_UNITS * N_CTRS
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    pio_en,
    input  logic                    pio_we,
    input  logic [ADDR_W-1:0]       pio_addr,
    input  logic [CTRL_W-1:0]       ctrl_wdata,
    input  logic [N_CNT*CNT_W-1:0]  cnt_all,
    input  logic [N_UNITS-1:0]      ovf_all,
    output logic [CNT_W-1:0]        pio_rdata,
    output logic                    pio_rvalid,
    output logic [CTRL_W-1:0]       ctrl_q,
    output logic [N_CNT-1:0]        cnt_wr,
    output logic                    stat_wr
);
    pio_state_e       state_q, state_d;
    logic             rd_req, wr_req;
    logic [CNT_W-1:0] rd_mux;

    assign rd_req  = pio_en & ~pio_we;
    assign wr_req  = pio_en & pio_we;
    assign stat_wr = wr_req & (pio_addr == ADDR_W'(ADDR_STAT));

    for (genvar i = 0; i < N_CNT; i++) begin : g_wdec
        assign cnt_wr[i] = wr_req & (pio_addr == ADDR_W'(ADDR_CNT_BASE + i));
    end

    always_comb begin
        rd_mux = '0;
        if (pio_addr == ADDR_W'(ADDR_CTRL)) begin
            rd_mux = CNT_W'(ctrl_q);
        end else if (pio_addr == ADDR_W'(ADDR_STAT)) begin
            rd_mux = CNT_W'(ovf_all);
        end else begin
            for (int i = 0; i < N_CNT; i++) begin
                if (pio_addr == ADDR_W'(ADDR_CNT_BASE + i)) begin
                    rd_mux = cnt_all[i*CNT_W +: CNT_W];
                end
            end
        end
    end

    always_comb begin
        unique case (state_q)
            PIO_IDLE: state_d = rd_req ? PIO_RESP : PIO_IDLE;
            PIO_RESP: state_d = rd_req ? PIO_RESP : PIO_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PIO_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pio_rdata <= '0;
            ctrl_q    <= '0;
        end else begin
            if (rd_req) begin
                pio_rdata <= rd_mux;
            end
            if (wr_req && pio_addr == ADDR_W'(ADDR_CTRL)) begin
                ctrl_q <= ctrl_wdata;
            end
        end
    end

    assign pio_rvalid = (state_q == PIO_RESP);
endmodule

// File: rtl/hm_grouped_monitor.sv
module hm_grouped_monitor #(
    parameter int N_UNITS  = 4,
    parameter int N_CTRS   = 5,
    parameter int N_GROUPS = 16,
    parameter int CNT_W    = 32,
    localparam int SEL_W    = $clog2(N_GROUPS),
    localparam int EV_UNIT  = N_GROUPS * N_CTRS,
    localparam int EV_W     = N_UNITS * EV_UNIT,
    localparam int N_CNT    = N_UNITS * N_CTRS,
    localparam int ADDR_W   = $clog2(N_CNT + 2),
    localparam int MARK_LSB = N_UNITS * SEL_W,
    localparam int PRIV_LSB = MARK_LSB + 2,
    localparam int CTRL_W   = PRIV_LSB + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [EV_W-1:0]    unit_evt,
    input  logic               proc_mark,
    input  logic               user_mode,
    input  logic               pio_en,
    input  logic               pio_we,
    input  logic [ADDR_W-1:0]  pio_addr,
    input  logic [CNT_W-1:0]   pio_wdata,
    output logic [CNT_W-1:0]   pio_rdata,
    output logic               pio_rvalid
);
    logic [CTRL_W-1:0]      ctrl_q;
    logic [N_CNT-1:0]       cnt_wr;
    logic                   stat_wr;
    logic                   count_ok;
    logic [N_CNT*CNT_W-1:0] cnt_flat;
    logic [N_UNITS-1:0]     ovf_q;

    hm_pio #(
        .N_UNITS(N_UNITS), .N_CTRS(N_CTRS), .CNT_W(CNT_W),
        .CTRL_W(CTRL_W), .ADDR_W(ADDR_W)
    ) u_pio (
        .clk        (clk),
        .rst_n      (rst_n),
        .pio_en     (pio_en),
        .pio_we     (pio_we),
        .pio_addr   (pio_addr),
        .ctrl_wdata (pio_wdata[CTRL_W-1:0]),
        .cnt_all    (cnt_flat),
        .ovf_all    (ovf_q),
        .pio_rdata  (pio_rdata),
        .pio_rvalid (pio_rvalid),
        .ctrl_q     (ctrl_q),
        .cnt_wr     (cnt_wr),
        .stat_wr    (stat_wr)
    );

    hm_qualify u_qual (
        .mark_mode (ctrl_q[MARK_LSB +: 2]),
        .priv_mode (ctrl_q[PRIV_LSB +: 2]),
        .proc_mark (proc_mark),
        .user_mode (user_mode),
        .count_ok  (count_ok)
    );

    for (genvar u = 0; u < N_UNITS; u++) begin : g_unit
        hm_unit_bank #(
            .N_CTRS(N_CTRS), .N_GROUPS(N_GROUPS), .CNT_W(CNT_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .evt      (unit_evt[u*EV_UNIT +: EV_UNIT]),
            .sel      (ctrl_q[u*SEL_W +: SEL_W]),
            .count_ok (count_ok),
            .wr       (cnt_wr[u*N_CTRS +: N_CTRS]),
            .wdata    (pio_wdata),
            .ovf_clr  (stat_wr & pio_wdata[u]),
            .cnt      (cnt_flat[u*N_CTRS*CNT_W +: N_CTRS*CNT_W]),
            .ovf      (ovf_q[u])
        );
    end
endmodule

// File: rtl/hm_monitor_chk.sv
module hm_monitor_chk #(
    parameter int N_CNT  = 20,
    parameter int N_UNITS = 4,
    parameter int CNT_W  = 32,
    parameter int CTRL_W = 20,
    parameter int ADDR_W = 5
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   pio_en,
    input logic                   pio_we,
    input logic [ADDR_W-1:0]      pio_addr,
    input logic [CNT_W-1:0]       pio_wdata,
    input logic                   pio_rvalid,
    input logic [CTRL_W-1:0]      ctrl_q,
    input logic [N_CNT*CNT_W-1:0] cnt_flat,
    input logic                   count_ok,
    input logic [N_UNITS-1:0]     ovf_q
);
    logic [CNT_W-1:0] cnt0;
    logic             any_wr;
    assign cnt0   = cnt_flat[CNT_W-1:0];
    assign any_wr = pio_en & pio_we;

    // R8: a read request is answered on the next cycle
    p_read_answer_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pio_en && !pio_we) |=> pio_rvalid);

    // R8: no strobe without a request
    p_no_stray_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(pio_en && !pio_we) |=> !pio_rvalid);

    // R9: control word takes the low bits of the write data
    p_ctrl_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && pio_addr == ADDR_W'(0)) |=> ctrl_q == $past(pio_wdata[CTRL_W-1:0]));

    // R4 R5: a blocked qualifier freezes every counter
    p_hold_blocked_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_ok && !any_wr) |=> $stable(cnt_flat));

    // R2: without a write a counter moves by at most one
    p_single_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !any_wr |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + CNT_W'(1)));

    // R3: overflow bit is sticky until its status word is written
    p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q[0] && !(any_wr && pio_addr == ADDR_W'(1))) |=> ovf_q[0]);

    // R7: a counter write loads the data
    p_cnt_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (any_wr && pio_addr == ADDR_W'(2)) |=> cnt0 == $past(pio_wdata));
endmodule

bind hm_grouped_monitor hm_monitor_chk #(
    .N_CNT(N_CNT), .N_UNITS(N_UNITS), .CNT_W(CNT_W),
    .CTRL_W(CTRL_W), .ADDR_W(ADDR_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pio_en     (pio_en),
    .pio_we     (pio_we),
    .pio_addr   (pio_addr),
    .pio_wdata  (pio_wdata),
    .pio_rvalid (pio_rvalid),
    .ctrl_q     (ctrl_q),
    .cnt_flat   (cnt_flat),
    .count_ok   (count_ok),
    .ovf_q      (ovf_q)
);

// File: tb/tb_hm_grouped_monitor.sv
`timescale 1ns/1ps
module tb_hm_grouped_monitor;
    localparam int NU = 4;
    localparam int NC = 5;
    localparam int NG = 16;
    localparam int EVU = NG * NC;
    localparam int EVW = NU * EVU;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [EVW-1:0] unit_evt = '0;
    logic           proc_mark = 1'b0;
    logic           user_mode = 1'b0;
    logic           pio_en = 1'b0;
    logic           pio_we = 1'b0;
    logic [4:0]     pio_addr = '0;
    logic [31:0]    pio_wdata = '0;
    logic [31:0]    pio_rdata;
    logic           pio_rvalid;

    hm_grouped_monitor dut (
        .clk(clk), .rst_n(rst_n), .unit_evt(unit_evt),
        .proc_mark(proc_mark), .user_mode(user_mode),
        .pio_en(pio_en), .pio_we(pio_we), .pio_addr(pio_addr),
        .pio_wdata(pio_wdata), .pio_rdata(pio_rdata), .pio_rvalid(pio_rvalid)
    );

    always #10 clk = ~clk;

    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done = 1'b0;
    logic [31:0] exp_cnt [NU][NC];
    logic [NU-1:0] exp_ovf;
    logic [19:0] ctrl_m;
    logic [31:0] lf = 32'h1d2c_3b4a;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic bit qual_ok();
        bit m, p;
        case (ctrl_m[17:16])
            2'b00: m = 1; 2'b01: m = proc_mark; 2'b10: m = !proc_mark; default: m = 0;
        endcase
        case (ctrl_m[19:18])
            2'b00: p = 1; 2'b01: p = user_mode; 2'b10: p = !user_mode; default: p = 0;
        endcase
        return m && p;
    endfunction

    function automatic void model_events(input logic [EVW-1:0] v);
        if (!qual_ok()) return;
        for (int u = 0; u < NU; u++) begin
            for (int c = 0; c < NC; c++) begin
                int g = int'(ctrl_m[u*4 +: 4]);
                if (v[u*EVU + g*NC + c]) begin
                    if (exp_cnt[u][c] == 32'hFFFF_FFFF) exp_ovf[u] = 1'b1;
                    exp_cnt[u][c] = exp_cnt[u][c] + 32'd1;
                end
            end
        end
    endfunction

    task automatic pio_write(input int a, input logic [31:0] d);
        pio_en = 1; pio_we = 1; pio_addr = 5'(a); pio_wdata = d;
        @(posedge clk); @(negedge clk);
        pio_en = 0; pio_we = 0;
        if (a == 0) ctrl_m = d[19:0];
        else if (a == 1) exp_ovf = exp_ovf & ~d[NU-1:0];
        else if (a >= 2 && a < 2 + NU*NC) exp_cnt[(a-2)/NC][(a-2)%NC] = d;
    endtask

    task automatic pio_read(input int a, output logic [31:0] d, output logic v);
        pio_en = 1; pio_we = 0; pio_addr = 5'(a);
        @(posedge clk); @(negedge clk);
        pio_en = 0;
        d = pio_rdata; v = pio_rvalid;
    endtask

    task automatic read_check(input string req, input int a, input logic [31:0] exp);
        logic [31:0] d; logic v;
        pio_read(a, d, v);
        check({req, " rvalid R8"}, {31'd0, v}, 32'd1);
        check(req, d, exp);
    endtask

    task automatic apply_evt(input logic [EVW-1:0] v);
        unit_evt = v;
        model_events(v);
        @(posedge clk); @(negedge clk);
        unit_evt = '0;
    endtask

    function automatic logic [EVW-1:0] next_pattern();
        logic [EVW-1:0] p;
        for (int w = 0; w < EVW/32; w++) begin
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
            p[w*32 +: 32] = lf ^ {lf[15:0], lf[31:16]};
        end
        return p;
    endfunction

    task automatic check_all(input string req);
        for (int u = 0; u < NU; u++)
            for (int c = 0; c < NC; c++)
                read_check(req, 2 + u*NC + c, exp_cnt[u][c]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [EVW-1:0] v;
        for (int u = 0; u < NU; u++) for (int c = 0; c < NC; c++) exp_cnt[u][c] = '0;
        exp_ovf = '0; ctrl_m = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);

        // R1 reset state
        check("R1 rvalid idle", {31'd0, pio_rvalid}, 32'd0);
        read_check("R1 ctrl", 0, 32'd0);
        read_check("R1 status", 1, 32'd0);
        check_all("R1 counters");

        // R2 R6 sweep over all groups, units on different groups
        for (int g = 0; g < NG; g++) begin
            logic [31:0] w = '0;
            for (int u = 0; u < NU; u++) w[u*4 +: 4] = 4'((g + u*5) % NG);
            pio_write(0, w);
            read_check("R6 kept after select change", 2, exp_cnt[0][0]);
            for (int k = 0; k < 3; k++) apply_evt(next_pattern());
            check_all("R2 group routing");
        end

        // R6 select change effective on next edge
        pio_write(0, 32'h0000_0007);
        apply_evt(EVW'(1) << (7*NC + 1));
        read_check("R6 new group next edge", 3, exp_cnt[0][1]);

        // R4 R5 qualifier sweep
        for (int mm = 0; mm < 4; mm++)
            for (int pv = 0; pv < 4; pv++)
                for (int pm = 0; pm < 2; pm++)
                    for (int pr = 0; pr < 2; pr++) begin
                        pio_write(0, {12'd0, 2'(pv), 2'(mm), 16'h0000});
                        proc_mark = pm[0]; user_mode = pr[0];
                        apply_evt('1);
                        proc_mark = 0; user_mode = 0;
                        read_check("R4 R5 qualifier", 2 + NC + 2, exp_cnt[1][2]);
                    end

        // R9 control readback
        pio_write(0, 32'hFFFF_FFFF);
        read_check("R9 ctrl upper bits", 0, 32'h000F_FFFF);
        pio_write(0, 32'h0);

        // R8 unmapped addresses
        for (int a = 22; a < 32; a++) read_check("R8 unmapped", a, 32'd0);

        // R3 wrap and overflow
        pio_write(2 + 2*NC + 3, 32'hFFFF_FFFF);
        read_check("R7 load no overflow", 1, 32'd0);
        apply_evt(EVW'(1) << (2*EVU + 3));
        read_check("R3 wrap value", 2 + 2*NC + 3, 32'd0);
        read_check("R3 status set", 1, {28'd0, exp_ovf});
        check("R3 model bit", {31'd0, exp_ovf[2]}, 32'd1);
        pio_write(1, 32'h4);
        read_check("R3 status cleared", 1, 32'd0);

        // R7 write wins over same-edge event
        pio_en = 1; pio_we = 1; pio_addr = 5'd2; pio_wdata = 32'd100;
        unit_evt = EVW'(1);
        @(posedge clk); @(negedge clk);
        pio_en = 0; pio_we = 0; unit_evt = '0;
        exp_cnt[0][0] = 32'd100;
        read_check("R7 write wins", 2, 32'd100);

        // R8 back-to-back reads and strobe drop
        begin
            logic [31:0] d; logic vv;
            pio_read(3, d, vv);
            pio_read(2, d, vv);
            check("R8 back-to-back data", d, 32'd100);
            check("R8 back-to-back valid", {31'd0, vv}, 32'd1);
            @(negedge clk);
            check("R8 strobe drops", {31'd0, pio_rvalid}, 32'd0);
        end

        check_all("R2 final");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule